// File: doc/BRIEF.md
# Debug scan-chain register access port

This block is a JTAG data register that lets an external debugger read and write a small bank of debug registers. A TAP controller outside the block supplies the capture, shift and update strobes and the TDI bit, and the block returns TDO. Each scan moves a 38-bit frame. The low 32 bits carry data, the next five bits carry a register address, and the top bit selects the direction: 1 writes and 0 reads.

A read takes two scans. At Update, a read frame only records its address. The following Capture loads the addressed register into the data field, and that second scan shifts the value out. A debugger that chains reads gets each result one scan late. The last scan of a run should point the recorded address at the comms control register, because reading it disturbs nothing. The bank holds debug control, debug status, vector catch, comms control and comms data. It also holds the value and mask storage for two watch units; the comparators that use this storage are outside the block. Bit 4 of debug control drives the monitor-mode enable output.

Top module: `dbg_scan_port`

## Requirements
- R1: After reset, every register reads zero, `tdo` is 0 and `monitor_en` is 0. The recorded read address is 4 (comms control), so the first Capture returns zero.
- R2: While `shift_dr` is high and `capture_dr` is low, the frame shifts one place toward bit 0 on each clock and `tdi` enters at bit 37. `tdo` always shows bit 0 of the frame, so a frame shifted in comes out unchanged 38 clocks later.
- R3: At `update_dr` with bit 37 = 1, bits 31:0 are written to the register whose address is in bits 36:32. The address is also recorded for the next Capture.
- R4: At `update_dr` with bit 37 = 0, only the address is recorded and no register changes. The next `capture_dr` loads that register into bits 31:0 and clears bits 37:32.
- R5: Register map and widths: debug control at 0 (6 bits), debug status at 1 (5 bits), vector catch at 2 (8 bits), comms control at 4 (6 bits), comms data at 5 (32 bits). Bits above a register's width are not stored and read as zero.
- R6: Addresses 3, 6, 7, 14, 15 and 22 to 31 map to no register. They read zero, and writes to them change no register.
- R7: Watch unit 0 occupies addresses 8 to 13 and watch unit 1 occupies addresses 16 to 21. At offsets 0 to 5 each unit holds the address value (32 bits), address mask (32), data value (32), data mask (32), control value (9) and control mask (8).
- R8: `monitor_en` equals bit 4 of debug control. Writing that bit as 0 selects halting debug.
- R9: Capturing comms control any number of times returns the same value and changes no register.
- R10: When `update_dr` and `capture_dr` are high in the same clock, the Capture returns the register at the previously recorded address, as it stood before that Update. The Update's write and its new address take effect for later scans.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| capture_dr | input | 1 | Capture strobe from the TAP |
| shift_dr | input | 1 | Shift strobe from the TAP |
| update_dr | input | 1 | Update strobe from the TAP |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the frame |
| monitor_en | output | 1 | Monitor-mode enable, debug control bit 4 |

## Verification
An Update and a Capture can fall in the same clock, and then one frame's write competes with the next frame's read. The bench provokes this by holding back the Update of a write to comms data and asserting it together with the Capture of the next scan, after the recorded address has already been set to comms data. The captured word must be the old comms data. A later scan must then show the newly written value, which proves that the write took effect and did not leak into the Capture of the same clock.

// File: rtl/dbg_scan_port.sv
module dbg_scan_port #(
  parameter int DW     = 32,
  parameter int CTRL_W = 6,
  parameter int STAT_W = 5,
  parameter int VC_W   = 8,
  parameter int CC_W   = 6,
  parameter int WCV_W  = 9,
  parameter int WCM_W  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic capture_dr,
  input  logic shift_dr,
  input  logic update_dr,
  input  logic tdi,
  output logic tdo,
  output logic monitor_en
);
  localparam int AW  = 5;
  localparam int SRW = DW + AW + 1;
  localparam logic [AW-1:0] PARK_ADDR = AW'(4);

  logic [SRW-1:0] sr;
  logic [AW-1:0]  lat;
  logic [DW-1:0]  ctl_q, stat_q, vc_q, cc_q, cd_q;
  logic [DW-1:0]  wp_q [2][6];
  logic [DW-1:0]  rd_data, wdat;

  wire [AW-1:0] sr_addr = sr[DW +: AW];
  wire          sr_dir  = sr[SRW-1];

  function automatic logic [DW-1:0] ones(input int w);
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) m[i] = (i < w);
    return m;
  endfunction

  function automatic logic is_wp(input logic [AW-1:0] a);
    return (a[4:3] == 2'b01 || a[4:3] == 2'b10) && a[2:0] < 3'd6;
  endfunction

  function automatic logic [DW-1:0] wmask(input logic [AW-1:0] a);
    logic [DW-1:0] m;
    m = '0;
    case (a)
      5'd0: m = ones(CTRL_W);
      5'd1: m = ones(STAT_W);
      5'd2: m = ones(VC_W);
      5'd4: m = ones(CC_W);
      5'd5: m = ones(DW);
      default:
        if (is_wp(a)) begin
          if (a[2:0] == 3'd4)      m = ones(WCV_W);
          else if (a[2:0] == 3'd5) m = ones(WCM_W);
          else                     m = ones(DW);
        end
    endcase
    return m;
  endfunction

  function automatic logic mapped(input logic [AW-1:0] a);
    return wmask(a) != '0;
  endfunction

  assign wdat       = sr[DW-1:0] & wmask(sr_addr);
  assign tdo        = sr[0];
  assign monitor_en = ctl_q[4];

  always_comb begin
    case (lat)
      5'd0:    rd_data = ctl_q;
      5'd1:    rd_data = stat_q;
      5'd2:    rd_data = vc_q;
      5'd4:    rd_data = cc_q;
      5'd5:    rd_data = cd_q;
      default: rd_data = is_wp(lat) ? wp_q[lat[4]][lat[2:0]] : '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      lat    <= PARK_ADDR;
      ctl_q  <= '0;
      stat_q <= '0;
      vc_q   <= '0;
      cc_q   <= '0;
      cd_q   <= '0;
      for (int u = 0; u < 2; u++)
        for (int k = 0; k < 6; k++) wp_q[u][k] <= '0;
    end else begin
      if (capture_dr)    sr <= {{(AW+1){1'b0}}, rd_data};
      else if (shift_dr) sr <= {tdi, sr[SRW-1:1]};
      if (update_dr) begin
        lat <= sr_addr;
        if (sr_dir) begin
          case (sr_addr)
            5'd0: ctl_q  <= wdat;
            5'd1: stat_q <= wdat;
            5'd2: vc_q   <= wdat;
            5'd4: cc_q   <= wdat;
            5'd5: cd_q   <= wdat;
            default: if (is_wp(sr_addr)) wp_q[sr_addr[4]][sr_addr[2:0]] <= wdat;
          endcase
        end
      end
    end
  end

  assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_dr && !capture_dr |=> tdo == $past(sr[1]));

  assert_capture_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    capture_dr |=> sr[SRW-1:DW] == '0);

  assert_read_still_R4: assert property (@(posedge clk) disable iff (!rst_n)
    update_dr && !sr_dir |=> $stable(ctl_q) && $stable(cd_q) && $stable(cc_q) && $stable(vc_q));

  assert_unmapped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    update_dr && sr_dir && !mapped(sr_addr) |=>
      $stable(ctl_q) && $stable(stat_q) && $stable(cd_q) && $stable(wp_q[0][0]) && $stable(wp_q[1][5]));

  assert_monitor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    update_dr && sr_dir && sr_addr == 5'd0 |=> monitor_en == $past(sr[4]));
endmodule

// File: tb/dbg_scan_port_bench.sv
module dbg_scan_port_bench;
  logic clk = 0, rst_n = 0;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
  logic tdo, monitor_en;

  dbg_scan_port u_dbg_scan_port (
    .clk(clk), .rst_n(rst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .tdi(tdi), .tdo(tdo), .monitor_en(monitor_en));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [37:0] exp_q[$];
  string       tag_q[$];
  logic [37:0] cap;
  event        got_ev;

  logic [31:0] mdl [32];
  logic [4:0]  lat;
  logic        p_dir;
  logic [4:0]  p_addr;
  logic [31:0] p_data;

  task automatic chk(input bit ok, input string tag, input logic [37:0] act, input logic [37:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bmask(input int a);
    case (a)
      0, 4: return 32'h3F;
      1: return 32'h1F;
      2, 13, 21: return 32'hFF;
      5, 8, 9, 10, 11, 16, 17, 18, 19: return 32'hFFFF_FFFF;
      12, 20: return 32'h1FF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic void apply(input logic d, input logic [4:0] a, input logic [31:0] v);
    lat = a;
    if (d) mdl[a] = v & bmask(a);
  endfunction

  always begin
    @(got_ev);
    chk(exp_q.size() > 0 && cap == exp_q[0], tag_q.size() > 0 ? tag_q[0] : "R4", cap,
        exp_q.size() > 0 ? exp_q[0] : 38'h0);
    if (exp_q.size() > 0) begin
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  task automatic scan(input logic dir, input logic [4:0] a, input logic [31:0] d,
                      input bit fuse, input bit upd, input bit flush, input string tag);
    logic [37:0] so, g, g2;
    logic [31:0] e;
    so = {dir, a, d};
    e = mdl[lat];
    if (fuse) apply(p_dir, p_addr, p_data);
    exp_q.push_back({6'b0, e});
    tag_q.push_back(tag);
    @(negedge clk) capture_dr = 1; update_dr = fuse;
    @(negedge clk) capture_dr = 0; update_dr = 0;
    for (int i = 0; i < 38; i++) begin
      shift_dr = 1; tdi = so[i]; g[i] = tdo;
      @(negedge clk);
    end
    if (flush) begin
      for (int i = 0; i < 38; i++) begin
        tdi = 0; g2[i] = tdo;
        @(negedge clk);
      end
      chk(g2 == so, "R2", g2, so);
      so = '0;
    end
    shift_dr = 0;
    cap = g;
    ->got_ev;
    if (upd) begin
      update_dr = 1;
      @(negedge clk) update_dr = 0;
      apply(so[37], so[36:32], so[31:0]);
    end else begin
      p_dir = so[37]; p_addr = so[36:32]; p_data = so[31:0];
    end
  endtask

  function automatic string rtag(input int a);
    if ((a >= 8 && a <= 13) || (a >= 16 && a <= 21)) return "R7";
    if (bmask(a) == 0) return "R6";
    return "R5";
  endfunction

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = 0;
    lat = 5'd4;
    repeat (3) @(negedge clk);
    chk(tdo == 0, "R1", {37'b0, tdo}, 38'h0);
    chk(monitor_en == 0, "R1", {37'b0, monitor_en}, 38'h0);
    rst_n = 1;
    @(negedge clk);
    scan(1, 5'd0, 32'hFFFF_FFFF, 0, 1, 0, "R1");
    chk(monitor_en == 1, "R8", {37'b0, monitor_en}, 38'h1);
    for (int a = 1; a < 32; a++)
      scan(1, 5'(a), (32'(a) * 32'h0101_0101) ^ 32'hA5C3_F00F, 0, 1, 0, "R3");
    for (int a = 0; a < 32; a++)
      scan(0, 5'(a), 32'hFFFF_FFFF, 0, 1, 0, a == 0 ? "R3" : rtag(a - 1));
    scan(0, 5'd4, 32'h0, 0, 1, 0, rtag(31));
    scan(0, 5'd4, 32'h1234_5678, 0, 1, 0, "R9");
    scan(0, 5'd4, 32'h0, 0, 1, 0, "R9");
    scan(1, 5'd0, 32'h0000_002F, 0, 1, 0, "R9");
    chk(monitor_en == 0, "R8", {37'b0, monitor_en}, 38'h0);
    scan(0, 5'd5, 32'h1234_5678, 0, 1, 0, "R8");
    scan(0, 5'd5, 32'h0BAD_0BAD, 0, 1, 0, "R4");
    scan(1, 5'd5, 32'hCAFE_F00D, 0, 0, 0, "R4");
    scan(0, 5'd2, 32'h0, 1, 1, 0, "R10");
    scan(0, 5'd5, 32'h0, 0, 1, 0, "R10");
    scan(0, 5'd4, 32'h0, 0, 1, 0, "R10");
    scan(1, 5'd9, 32'h5A5A_0F0F, 0, 1, 1, "R2");
    scan(0, 5'd4, 32'h0, 0, 1, 0, "R2");
    #1;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R1 watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule